// File: doc/BRIEF.md
# Floating-Point Condition Compare Unit

This block executes a floating-point compare operation. It decodes a 32-bit compare instruction word and compares two operand values that the register file has already read. The operands are single or double precision. The block then stores the 1-bit outcome in a small bank of eight condition flags. A 5-bit condition field selects one of eleven predicates. These predicates are built from the four basic relations: unordered, less, equal and greater. The lowest bit of the condition field chooses between the quiet form and the signaling form of the chosen predicate.

Every accepted compare takes one clock cycle. On the edge where the instruction is issued, the selected flag entry is updated, a completion pulse is raised and an invalid-operation pulse may be raised. The surrounding FPU ORs the invalid pulse into its sticky status register. The block rejects any encoding it does not recognise with an illegal-operation pulse. A compare issued while the unit is disabled produces a fault pulse instead of a result. A registered read port lets the rest of the pipeline inspect any of the flags.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `cmp_done`, `invalid_pulse`, `illegal_pulse` and `unit_off_fault` are 0, and all eight flags read back as 0.
- R2: An instruction is accepted only if bits 31:20 equal 0x0C1 (single precision) or 0x0C2 (double precision) and bits 4:3 equal 00. Any other encoding raises `illegal_pulse` for one cycle and writes no flag.
- R3: The condition field is bits 19:15, and the predicate is taken from bits 19:16. The even codes select these predicates: 0 never true, 2 lhs<rhs, 4 lhs==rhs, 6 lhs<=rhs, 8 unordered, 10 unordered or less, 12 unordered or equal, 14 unordered or less-or-equal, 16 less or greater, 20 less, equal or greater, 24 unordered, less or greater. Here lhs is `opnd_lhs` and rhs is `opnd_rhs`.
- R4: Each odd code from 1 to 25 gives the same result as the even code one below it. It differs only in how the invalid flag is raised.
- R5: Codes 18, 19, 22, 23 and 26 to 31 raise `illegal_pulse`, leave the flags unchanged and never raise `invalid_pulse`.
- R6: If either operand is NaN, codes 16 and 20 give 0 and code 24 gives 1.
- R7: +0 and -0 compare equal. A negative value is less than a positive one. Between two negative values, the one with the larger magnitude is the smaller.
- R8: Double precision uses all 64 bits of each operand. Single precision uses only bits 31:0, and bits 63:32 have no effect.
- R9: A quiet code raises `invalid_pulse` only when an operand is a signaling NaN. A signaling NaN has all exponent bits set, a nonzero fraction and the top fraction bit clear. A signaling code raises `invalid_pulse` when either operand is any NaN. Codes 0 and 1 also follow this rule, even though their result is always 0.
- R10: After an accepted compare is issued, on the next rising edge the result is written to the flag selected by bits 2:0 and `cmp_done` is 1 for one cycle. `flag_rd_data` shows the flag at `flag_rd_idx` as it was at the previous edge.
- R11: A compare issued while `fpu_enable` is 0 writes no flag and raises `unit_off_fault`. In that case `cmp_done`, `illegal_pulse` and `invalid_pulse` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A compare instruction is presented this cycle |
| insn | input | 32 | Compare instruction word |
| opnd_lhs | input | 64 | First source operand value |
| opnd_rhs | input | 64 | Second source operand value |
| fpu_enable | input | 1 | Unit enable; a compare issued while this is low faults |
| flag_rd_idx | input | 3 | Flag read index |
| flag_rd_data | output | 1 | Registered flag read data |
| cmp_done | output | 1 | Pulse: an accepted compare wrote its flag |
| invalid_pulse | output | 1 | Pulse: invalid-operation exception for the sticky status |
| illegal_pulse | output | 1 | Pulse: rejected encoding |
| unit_off_fault | output | 1 | Pulse: compare issued while the unit was disabled |

## Verification
The vector table pairs ordinary numbers, equal values, signed zeros, pairs of negative values, infinities, quiet NaNs and signaling NaNs with both the quiet and the signaling form of each predicate. This separates a wrong relation from a wrong exception rule: a quiet NaN gives the same result under both forms but a different invalid flag. Single-precision vectors place a signaling-NaN pattern in the unused upper half of each operand, so any leak of those bits changes both the result and the flag. Directed cases first set a flag to 1. They then issue reserved codes, bad opcodes, nonzero bits 4:3 and compares while the unit is disabled, and read the flag back to confirm it was left untouched.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;

  localparam logic [11:0] OPC_SINGLE = 12'h0C1;
  localparam logic [11:0] OPC_DOUBLE = 12'h0C2;

  // predicate selectors: condition field bits 4:1
  localparam logic [3:0] PR_NEVER = 4'd0;
  localparam logic [3:0] PR_LT    = 4'd1;
  localparam logic [3:0] PR_EQ    = 4'd2;
  localparam logic [3:0] PR_LE    = 4'd3;
  localparam logic [3:0] PR_UN    = 4'd4;
  localparam logic [3:0] PR_ULT   = 4'd5;
  localparam logic [3:0] PR_UEQ   = 4'd6;
  localparam logic [3:0] PR_ULE   = 4'd7;
  localparam logic [3:0] PR_NE    = 4'd8;
  localparam logic [3:0] PR_ORD   = 4'd10;
  localparam logic [3:0] PR_UNE   = 4'd12;

  typedef struct packed {
    logic unord;
    logic lt;
    logic eq;
    logic gt;
    logic any_nan;
    logic any_snan;
  } rel_t;

  typedef struct packed {
    logic       fmt_ok;
    logic       is_dbl;
    logic [4:0] cond;
    logic [2:0] cd;
  } dec_t;
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic [11:0] opc;
  assign opc = insn[31:20];

  always_comb begin
    dec.is_dbl = (opc == OPC_DOUBLE);
    dec.fmt_ok = ((opc == OPC_SINGLE) || (opc == OPC_DOUBLE)) && (insn[4:3] == 2'b00);
    dec.cond   = insn[19:15];
    dec.cd     = insn[2:0];
  end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] lhs,
  input  logic [EXP_W+FRAC_W:0] rhs,
  output rel_t                  rel
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic              s_l, s_r;
  logic [EXP_W-1:0]  e_l, e_r;
  logic [FRAC_W-1:0] f_l, f_r;
  logic [W-2:0]      m_l, m_r;
  logic nan_l, nan_r, snan_l, snan_r, unord, zeros, same, lt_raw;

  assign s_l = lhs[W-1];
  assign s_r = rhs[W-1];
  assign e_l = lhs[W-2:FRAC_W];
  assign e_r = rhs[W-2:FRAC_W];
  assign f_l = lhs[FRAC_W-1:0];
  assign f_r = rhs[FRAC_W-1:0];
  assign m_l = lhs[W-2:0];
  assign m_r = rhs[W-2:0];

  assign nan_l  = (&e_l) && (|f_l);
  assign nan_r  = (&e_r) && (|f_r);
  assign snan_l = nan_l && !f_l[FRAC_W-1];
  assign snan_r = nan_r && !f_r[FRAC_W-1];
  assign unord  = nan_l || nan_r;
  assign zeros  = (m_l == '0) && (m_r == '0);
  assign same   = !unord && ((lhs == rhs) || zeros);

  always_comb begin
    unique case ({s_l, s_r})
      2'b10:   lt_raw = 1'b1;
      2'b01:   lt_raw = 1'b0;
      2'b00:   lt_raw = (m_l < m_r);
      default: lt_raw = (m_r < m_l);
    endcase
  end

  always_comb begin
    rel.unord    = unord;
    rel.eq       = same;
    rel.lt       = !unord && !same && lt_raw;
    rel.gt       = !unord && !same && !lt_raw;
    rel.any_nan  = unord;
    rel.any_snan = snan_l || snan_r;
  end
endmodule

// File: rtl/fcmp_pred.sv
module fcmp_pred
  import fcmp_pkg::*;
(
  input  rel_t       rel,
  input  logic [4:0] cond,
  output logic       cond_ok,
  output logic       result,
  output logic       raise_inv
);
  always_comb begin
    cond_ok = 1'b1;
    result  = 1'b0;
    case (cond[4:1])
      PR_NEVER: result = 1'b0;
      PR_LT:    result = rel.lt;
      PR_EQ:    result = rel.eq;
      PR_LE:    result = rel.lt | rel.eq;
      PR_UN:    result = rel.unord;
      PR_ULT:   result = rel.unord | rel.lt;
      PR_UEQ:   result = rel.unord | rel.eq;
      PR_ULE:   result = rel.unord | rel.lt | rel.eq;
      PR_NE:    result = rel.lt | rel.gt;
      PR_ORD:   result = rel.lt | rel.eq | rel.gt;
      PR_UNE:   result = rel.unord | rel.lt | rel.gt;
      default:  cond_ok = 1'b0;
    endcase
    // odd codes are the signaling forms: any NaN traps
    raise_inv = cond[0] ? rel.any_nan : rel.any_snan;
  end
endmodule

// File: rtl/fcmp_flagfile.sv
module fcmp_flagfile #(
  parameter int NFLAG = 8,
  localparam int IDX_W = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic             rdata
);
  logic [NFLAG-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      rdata  <= 1'b0;
    end else begin
      if (we) bits_q[widx] <= wdata;
      rdata <= bits_q[ridx];
    end
  end

  // R10: a flag written at one edge is visible on the read port one edge later
  p_wr_then_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (we && (ridx == widx)) |=> ##1 (rdata == $past(wdata, 2)));
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NFLAG  = 8,
  localparam int IDX_W = $clog2(NFLAG),
  localparam int SP_W  = 1 + SP_EXP + SP_FRAC,
  localparam int DP_W  = 1 + DP_EXP + DP_FRAC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [31:0]       insn,
  input  logic [DATA_W-1:0] opnd_lhs,
  input  logic [DATA_W-1:0] opnd_rhs,
  input  logic              fpu_enable,
  input  logic [IDX_W-1:0]  flag_rd_idx,
  output logic              flag_rd_data,
  output logic              cmp_done,
  output logic              invalid_pulse,
  output logic              illegal_pulse,
  output logic              unit_off_fault
);
  dec_t dec;
  rel_t rel_sp, rel_dp, rel;
  logic cond_ok, result, raise_inv, legal, take, wr_en;

  fcmp_decode u_dec (.insn(insn), .dec(dec));

  generate
    if (SP_W <= DATA_W) begin : g_sp
      fcmp_relate #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_rel (
        .lhs(opnd_lhs[SP_W-1:0]), .rhs(opnd_rhs[SP_W-1:0]), .rel(rel_sp));
    end else begin : g_sp_none
      assign rel_sp = '0;
    end
    if (DP_W <= DATA_W) begin : g_dp
      fcmp_relate #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_rel (
        .lhs(opnd_lhs[DP_W-1:0]), .rhs(opnd_rhs[DP_W-1:0]), .rel(rel_dp));
    end else begin : g_dp_none
      assign rel_dp = '0;
    end
  endgenerate

  assign rel = dec.is_dbl ? rel_dp : rel_sp;

  fcmp_pred u_pred (
    .rel(rel), .cond(dec.cond), .cond_ok(cond_ok),
    .result(result), .raise_inv(raise_inv));

  assign legal = dec.fmt_ok && cond_ok;
  assign take  = issue_valid && fpu_enable;
  assign wr_en = take && legal;

  fcmp_flagfile #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .we(wr_en), .widx(dec.cd[IDX_W-1:0]),
    .wdata(result), .ridx(flag_rd_idx), .rdata(flag_rd_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_done       <= 1'b0;
      invalid_pulse  <= 1'b0;
      illegal_pulse  <= 1'b0;
      unit_off_fault <= 1'b0;
    end else begin
      cmp_done       <= wr_en;
      invalid_pulse  <= wr_en && raise_inv;
      illegal_pulse  <= take && !legal;
      unit_off_fault <= issue_valid && !fpu_enable;
    end
  end

  // R11/R5: at most one outcome pulse per issued compare
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmp_done, illegal_pulse, unit_off_fault}));
  // R9: the exception pulse only accompanies a written result
  p_inv_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    invalid_pulse |-> cmp_done);
  // R10: completion only follows an issue
  p_done_after_issue_r10: assert property (@(posedge clk) disable iff (rst)
    cmp_done |-> $past(issue_valid));
  // R3: the selected operand pair is in exactly one relation
  p_rel_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({rel.unord, rel.lt, rel.eq, rel.gt}) == 1);
  // R11: disabled unit never completes
  p_off_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !fpu_enable) |=> !cmp_done);
endmodule

// File: tb/sim_fcmp_flag_unit.sv
module sim_fcmp_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] opnd_lhs = '0, opnd_rhs = '0;
  logic fpu_enable = 1'b1;
  logic [2:0] flag_rd_idx = '0;
  logic flag_rd_data, cmp_done, invalid_pulse, illegal_pulse, unit_off_fault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fcmp_flag_unit u0 (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .insn(insn),
    .opnd_lhs(opnd_lhs), .opnd_rhs(opnd_rhs), .fpu_enable(fpu_enable),
    .flag_rd_idx(flag_rd_idx), .flag_rd_data(flag_rd_data), .cmp_done(cmp_done),
    .invalid_pulse(invalid_pulse), .illegal_pulse(illegal_pulse),
    .unit_off_fault(unit_off_fault));

  localparam logic [31:0] HI  = 32'h7FF00001; // junk upper half for single (R8)
  localparam logic [31:0] S1  = 32'h3F800000, S2 = 32'h40000000;
  localparam logic [31:0] SM1 = 32'hBF800000, SM2 = 32'hC0000000;
  localparam logic [31:0] SP0 = 32'h00000000, SN0 = 32'h80000000;
  localparam logic [31:0] SQN = 32'h7FC00000, SSN = 32'h7F800001;
  localparam logic [63:0] D1  = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
  localparam logic [63:0] DM2 = 64'hC000000000000000, DINF = 64'h7FF0000000000000;
  localparam logic [63:0] DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001;
  localparam logic [63:0] DP0 = 64'h0, DN0 = 64'h8000000000000000;

  // {dbl, cond, lhs, rhs, expected result, expected invalid}
  localparam int NV = 34;
  localparam logic [135:0] VEC [NV] = '{
    {1'b0, 5'd2,  HI, S1,  HI, S2,  1'b1, 1'b0},
    {1'b0, 5'd2,  HI, S2,  HI, S1,  1'b0, 1'b0},
    {1'b0, 5'd4,  HI, S1,  HI, S1,  1'b1, 1'b0},
    {1'b0, 5'd6,  HI, S1,  HI, S2,  1'b1, 1'b0},
    {1'b0, 5'd6,  HI, S2,  HI, S1,  1'b0, 1'b0},
    {1'b0, 5'd4,  HI, SP0, HI, SN0, 1'b1, 1'b0},
    {1'b0, 5'd2,  HI, SM1, HI, S1,  1'b1, 1'b0},
    {1'b0, 5'd2,  HI, SM1, HI, SM2, 1'b0, 1'b0},
    {1'b0, 5'd2,  HI, SM2, HI, SM1, 1'b1, 1'b0},
    {1'b0, 5'd8,  HI, SQN, HI, S1,  1'b1, 1'b0},
    {1'b0, 5'd9,  HI, SQN, HI, S1,  1'b1, 1'b1},
    {1'b0, 5'd0,  HI, SSN, HI, S1,  1'b0, 1'b1},
    {1'b0, 5'd1,  HI, SQN, HI, S1,  1'b0, 1'b1},
    {1'b0, 5'd0,  HI, SQN, HI, S1,  1'b0, 1'b0},
    {1'b0, 5'd16, HI, SQN, HI, S1,  1'b0, 1'b0},
    {1'b0, 5'd16, HI, S1,  HI, S2,  1'b1, 1'b0},
    {1'b0, 5'd20, HI, S1,  HI, SQN, 1'b0, 1'b0},
    {1'b0, 5'd20, HI, S1,  HI, S2,  1'b1, 1'b0},
    {1'b0, 5'd24, HI, SQN, HI, S1,  1'b1, 1'b0},
    {1'b0, 5'd24, HI, S1,  HI, S1,  1'b0, 1'b0},
    {1'b0, 5'd10, HI, SQN, HI, S1,  1'b1, 1'b0},
    {1'b0, 5'd10, HI, S2,  HI, S1,  1'b0, 1'b0},
    {1'b0, 5'd12, HI, S1,  HI, S1,  1'b1, 1'b0},
    {1'b0, 5'd14, HI, S2,  HI, S1,  1'b0, 1'b0},
    {1'b0, 5'd15, HI, S1,  HI, SSN, 1'b1, 1'b1},
    {1'b0, 5'd25, HI, S1,  HI, S2,  1'b1, 1'b0},
    {1'b1, 5'd3,  D1,  D2,  1'b1, 1'b0},
    {1'b1, 5'd2,  DQN, D1,  1'b0, 1'b0},
    {1'b1, 5'd3,  DQN, D1,  1'b0, 1'b1},
    {1'b1, 5'd2,  DSN, D1,  1'b0, 1'b1},
    {1'b1, 5'd5,  DP0, DN0, 1'b1, 1'b0},
    {1'b1, 5'd2,  DINF, D1, 1'b0, 1'b0},
    {1'b1, 5'd17, DM2, DINF, 1'b1, 1'b0},
    {1'b1, 5'd21, D1,  DQN, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic dbl, input logic [4:0] cond, input logic [2:0] cd);
    return {dbl ? 12'h0C2 : 12'h0C1, cond, 5'd7, 5'd3, 2'b00, cd};
  endfunction

  // issue one op, sample pulses after the edge, then read flag ridx one edge later
  task automatic run(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                     input logic en, input logic [2:0] ridx,
                     output logic d, output logic iv, output logic il, output logic f,
                     output logic rd);
    @(negedge clk);
    insn = ins; opnd_lhs = a; opnd_rhs = b; fpu_enable = en; issue_valid = 1'b1;
    @(negedge clk);
    d = cmp_done; iv = invalid_pulse; il = illegal_pulse; f = unit_off_fault;
    issue_valid = 1'b0; fpu_enable = 1'b1; flag_rd_idx = ridx;
    @(negedge clk);
    rd = flag_rd_data;
  endtask

  initial begin
    logic d, iv, il, f, rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done", cmp_done, 1'b0);
    chk("R1", "invalid", invalid_pulse, 1'b0);
    chk("R1", "illegal", illegal_pulse, 1'b0);
    chk("R1", "fault", unit_off_fault, 1'b0);
    for (int k = 0; k < 8; k++) begin
      flag_rd_idx = 3'(k);
      @(negedge clk);
      chk("R1", "flag after reset", flag_rd_data, 1'b0);
    end

    // table walk: R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [135:0] v;
      v = VEC[i];
      run(mk(v[135], v[134:130], 3'(i % 8)), v[129:66], v[65:2], 1'b1, 3'(i % 8), d, iv, il, f, rd);
      chk("R10", $sformatf("vec %0d done", i), d, 1'b1);
      chk("R2", $sformatf("vec %0d illegal", i), il, 1'b0);
      chk("R9", $sformatf("vec %0d invalid", i), iv, v[0]);
      chk("R3 R4 R6 R7 R8", $sformatf("vec %0d flag", i), rd, v[1]);
    end

    // prime flag 3 to 1
    run(mk(1'b0, 5'd2, 3'd3), {HI, S1}, {HI, S2}, 1'b1, 3'd3, d, iv, il, f, rd);
    chk("R10", "prime flag 3", rd, 1'b1);

    // R5 reserved condition codes
    foreach (VEC[j]) begin
      logic [4:0] c;
      if (j >= 6) break;
      c = (j == 0) ? 5'd18 : (j == 1) ? 5'd19 : (j == 2) ? 5'd22 :
          (j == 3) ? 5'd23 : (j == 4) ? 5'd26 : 5'd31;
      run(mk(1'b0, c, 3'd3), {HI, SSN}, {HI, S1}, 1'b1, 3'd3, d, iv, il, f, rd);
      chk("R5", $sformatf("code %0d illegal", c), il, 1'b1);
      chk("R5", $sformatf("code %0d done", c), d, 1'b0);
      chk("R5", $sformatf("code %0d invalid", c), iv, 1'b0);
      chk("R5", $sformatf("code %0d flag kept", c), rd, 1'b1);
    end

    // R2 bad opcode and nonzero bits 4:3
    run({12'h0C3, 5'd0, 5'd1, 5'd2, 2'b00, 3'd3}, {HI, S2}, {HI, S1}, 1'b1, 3'd3, d, iv, il, f, rd);
    chk("R2", "bad opcode illegal", il, 1'b1);
    chk("R2", "bad opcode flag kept", rd, 1'b1);
    run({12'h0C1, 5'd0, 5'd1, 5'd2, 2'b01, 3'd3}, {HI, S2}, {HI, S1}, 1'b1, 3'd3, d, iv, il, f, rd);
    chk("R2", "bits 4:3 illegal", il, 1'b1);
    chk("R2", "bits 4:3 done", d, 1'b0);
    chk("R2", "bits 4:3 flag kept", rd, 1'b1);

    // R11 disabled unit
    run(mk(1'b0, 5'd1, 3'd3), {HI, SSN}, {HI, S1}, 1'b0, 3'd3, d, iv, il, f, rd);
    chk("R11", "fault", f, 1'b1);
    chk("R11", "done", d, 1'b0);
    chk("R11", "illegal", il, 1'b0);
    chk("R11", "invalid", iv, 1'b0);
    chk("R11", "flag kept", rd, 1'b1);

    // R10 single-cycle pulse
    @(negedge clk);
    chk("R10", "done drops", cmp_done, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule